// File: doc/BRIEF.md
# Audio Master Clock Generator

This block produces the frame clock and the bit clock of an audio converter that drives its serial port as clock master. Both clocks come from one reference clock through counters and clock enables, so every output is a register in the reference clock domain and no derived clock feeds any flop. The bit clock always runs at 64 times the frame rate. A two-bit speed select and a fast-reference flag set how many reference cycles make up one bit-clock half period.

The reference input `clk_i` must run at twice the converter master clock (MCLK). This is what lets the quad-speed divide-by-one case exist as a registered toggle. A one-cycle frame-start strobe tells a serializer where a frame begins. A small control state machine has two states: HOLD, where all outputs are low and the divider chain is cleared, and RUN. The transitions are START (HOLD to RUN on a valid speed code), RECONF (RUN to HOLD when the speed code or the fast flag differs from the latched setting) and STAY in either state. A reserved speed code keeps the machine in HOLD.

Top module: `audio_mclk_gen`

## Requirements
- R1: While `rst_ni` is low, `sclk_o`, `lrck_o` and `frame_start_o` are low. In the first RUN cycle after release, `sclk_o` and `lrck_o` are low.
- R2: `speed_i` is 2'b00 for single, 2'b01 for double and 2'b10 for quad speed. With `fast_i` low, one bit-clock half period lasts 4, 2 or 1 `clk_i` cycles for these codes, which gives MCLK/LRCK ratios of 256, 128 and 64.
- R3: With `fast_i` high, every bit-clock half period is twice as long as it is with `fast_i` low (8, 4 or 2 cycles), which gives MCLK/LRCK ratios of 512, 256 and 128.
- R4: Counted from the first RUN cycle, each LRCK period holds exactly 64 bit-clock periods. LRCK is low for the first 32 and high for the last 32, and it changes only together with a bit-clock falling edge.
- R5: `frame_start_o` is a one-cycle pulse. It is high in the second RUN cycle and in the cycle in which LRCK falls.
- R6: Speed code 2'b11 is reserved. From the second cycle after it is applied, all three outputs stay low.
- R7: A change of `speed_i` or `fast_i` while running gives one more normal output cycle, then one cleared cycle in HOLD. After that the outputs restart in phase from the first RUN cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the converter master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed_i | input | 2 | Speed select (00 single, 01 double, 10 quad, 11 reserved) |
| fast_i | input | 1 | Fast master clock, adds a divide-by-two |
| sclk_o | output | 1 | Bit clock, 64 times the frame rate |
| lrck_o | output | 1 | Frame clock, low for the first half of the frame |
| frame_start_o | output | 1 | One-cycle strobe at the start of each frame |

## Verification
The bench builds the block with its default 64 bit slots per frame and a three-bit half-period counter. These values make every speed and fast-flag combination reachable, from the one-cycle quad toggle up to the eight-cycle single-speed half period. With those settings a full frame spans 128 to 1024 reference cycles. This is short enough to compare more than one whole frame of every output cycle by cycle after a reset release, after leaving the reserved code, and after a direct reconfiguration.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // log2 of the bit-clock half period in reference cycles
    function automatic logic [1:0] half_shift(input speed_e spd, input logic fast);
        logic [1:0] base;
        unique case (spd)
            SPD_SINGLE: base = 2'd2;
            SPD_DOUBLE: base = 2'd1;
            default:    base = 2'd0;
        endcase
        return base + {1'b0, fast};
    endfunction

endpackage

// File: rtl/acg_ctrl.sv
module acg_ctrl
    import acg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] speed_i,
    input  logic       fast_i,
    output logic       run_o,
    output logic [1:0] shift_o
);

    state_e state_q, state_d;
    speed_e spd_q, spd_d;
    logic   fast_q, fast_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HOLD;
            spd_q   <= SPD_SINGLE;
            fast_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            spd_q   <= spd_d;
            fast_q  <= fast_d;
        end
    end

    // next state: START, RECONF, STAY
    always_comb begin
        state_d = state_q;
        spd_d   = spd_q;
        fast_d  = fast_q;
        unique case (state_q)
            ST_HOLD: begin
                if (speed_e'(speed_i) != SPD_RSVD) begin
                    state_d = ST_RUN;
                    spd_d   = speed_e'(speed_i);
                    fast_d  = fast_i;
                end
            end
            ST_RUN: begin
                if (speed_e'(speed_i) != spd_q || fast_i != fast_q) begin
                    state_d = ST_HOLD;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        run_o   = (state_q == ST_RUN);
        shift_o = half_shift(spd_q, fast_q);
    end

endmodule

// File: rtl/acg_tick.sv
module acg_tick #(
    parameter int HCNT_W = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [1:0] shift_i,
    output logic       tick_o
);

    logic [HCNT_W-1:0] cnt_q;
    logic [HCNT_W:0]   span;
    logic [HCNT_W-1:0] limit;

    always_comb begin
        span   = (HCNT_W+1)'(1) << shift_i;
        limit  = HCNT_W'(span - (HCNT_W+1)'(1));
        tick_o = run_i && (cnt_q == limit);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + HCNT_W'(1);
        end
    end

endmodule

// File: rtl/acg_frame.sv
module acg_frame #(
    parameter int SLOTS = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    output logic sclk_o,
    output logic lrck_o,
    output logic frame_start_o
);

    localparam int BCNT_W = $clog2(SLOTS);

    logic [BCNT_W-1:0] bcnt_q;
    logic [BCNT_W-1:0] bnext;
    logic              run_q;

    assign bnext = bcnt_q + BCNT_W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_o        <= 1'b0;
            lrck_o        <= 1'b0;
            frame_start_o <= 1'b0;
            bcnt_q        <= '0;
            run_q         <= 1'b0;
        end else begin
            run_q <= run_i;
            if (!run_i) begin
                sclk_o        <= 1'b0;
                lrck_o        <= 1'b0;
                frame_start_o <= 1'b0;
                bcnt_q        <= '0;
            end else begin
                frame_start_o <= !run_q;
                if (tick_i) begin
                    sclk_o <= !sclk_o;
                    if (sclk_o) begin
                        bcnt_q        <= bnext;
                        lrck_o        <= bnext[BCNT_W-1];
                        frame_start_o <= (bnext == '0);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen #(
    parameter int SLOTS  = 64,
    parameter int HCNT_W = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] speed_i,
    input  logic       fast_i,
    output logic       sclk_o,
    output logic       lrck_o,
    output logic       frame_start_o
);

    logic       run;
    logic       tick;
    logic [1:0] shift;

    acg_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .speed_i (speed_i),
        .fast_i  (fast_i),
        .run_o   (run),
        .shift_o (shift)
    );

    acg_tick #(.HCNT_W(HCNT_W)) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .shift_i (shift),
        .tick_o  (tick)
    );

    acg_frame #(.SLOTS(SLOTS)) u_frame (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .run_i         (run),
        .tick_i        (tick),
        .sclk_o        (sclk_o),
        .lrck_o        (lrck_o),
        .frame_start_o (frame_start_o)
    );

endmodule

// File: rtl/acg_checker.sv
module acg_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] speed_i,
    input logic       run,
    input logic       sclk_o,
    input logic       lrck_o,
    input logic       frame_start_o
);

    a_r1_reset_low: assert property (@(posedge clk_i)
        !rst_ni |-> (!sclk_o && !lrck_o && !frame_start_o));

    a_r4_lrck_on_sclk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run) && (lrck_o != $past(lrck_o))) |-> ($past(sclk_o) && !sclk_o));

    a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |=> !frame_start_o);

    a_r5_strobe_on_lrck_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run) && $fell(lrck_o)) |-> frame_start_o);

    a_r6_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (speed_i == 2'b11 && $past(speed_i) == 2'b11 && $past(speed_i, 2) == 2'b11)
        |-> (!sclk_o && !lrck_o && !frame_start_o));

endmodule

bind audio_mclk_gen acg_checker u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .speed_i       (speed_i),
    .run           (run),
    .sclk_o        (sclk_o),
    .lrck_o        (lrck_o),
    .frame_start_o (frame_start_o)
);

// File: tb/audio_mclk_gen_tb.sv
`timescale 1ns/1ps
module audio_mclk_gen_tb;

    localparam int SLOTS = 64;

    typedef struct {
        bit    chk;
        bit    sclk;
        bit    lrck;
        bit    fs;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] speed = 2'b00;
    logic       fast = 1'b0;
    logic       sclk, lrck, fs;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t expq[$];

    always #4 clk = ~clk;

    audio_mclk_gen u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .speed_i       (speed),
        .fast_i        (fast),
        .sclk_o        (sclk),
        .lrck_o        (lrck),
        .frame_start_o (fs)
    );

    // monitor: pop one expected item per cycle, after the edge settles
    always begin
        @(posedge clk);
        #2;
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            if (e.chk) begin
                checks++;
                if (sclk !== e.sclk || lrck !== e.lrck || fs !== e.fs) begin
                    fails++;
                    $display("FAIL %s: got sclk=%b lrck=%b fs=%b, expected sclk=%b lrck=%b fs=%b",
                             e.req, sclk, lrck, fs, e.sclk, e.lrck, e.fs);
                end
            end
        end
    end

    task automatic push_skip(input int n);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.chk = 0; e.sclk = 0; e.lrck = 0; e.fs = 0; e.req = "";
            expq.push_back(e);
        end
    endtask

    task automatic push_zero(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.chk = 1; e.sclk = 0; e.lrck = 0; e.fs = 0; e.req = req;
            expq.push_back(e);
        end
    endtask

    // expected output from first RUN cycle, half period h cycles
    task automatic push_run(input int h, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int b;
            b      = (i / (2 * h)) % SLOTS;
            e.chk  = 1;
            e.sclk = ((i / h) % 2) == 1;
            e.lrck = b >= SLOTS / 2;
            e.fs   = (i == 1) || (i > 0 && (i % (2 * h * SLOTS)) == 0);
            e.req  = req;
            expq.push_back(e);
        end
    endtask

    task automatic drain();
        wait (expq.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        // R1: outputs low under reset
        push_zero(4, "R1");
        drain();
        // release reset, single speed, normal reference
        rst_ni = 1'b1;
        push_run(4, 2 * 4 * SLOTS * 2 + 10, "R2/R4/R5 single");
        drain();

        // R6: reserved code from running
        speed = 2'b11;
        push_skip(1);
        push_zero(20, "R6");
        drain();

        speed = 2'b01;
        push_run(2, 2 * 2 * SLOTS * 2 + 10, "R2 double");
        drain();

        speed = 2'b11;
        push_skip(1);
        push_zero(6, "R6");
        drain();

        speed = 2'b10;
        push_run(1, 2 * SLOTS * 2 + 10, "R2 quad");
        drain();

        // R7 direct change of the fast flag while running; R3 doubled period
        fast = 1'b1;
        push_skip(1);
        push_run(2, 2 * 2 * SLOTS * 2 + 10, "R3/R7 quad fast");
        drain();

        speed = 2'b00;
        push_skip(1);
        push_run(8, 2 * 8 * SLOTS + 40, "R3/R7 single fast");
        drain();

        speed = 2'b01;
        push_skip(1);
        push_run(4, 2 * 4 * SLOTS + 40, "R3/R7 double fast");
        drain();

        // R1: reset mid-run, then restart in phase
        rst_ni = 1'b0;
        push_zero(5, "R1 mid-run");
        drain();
        rst_ni = 1'b1;
        push_run(4, 100, "R1 restart");
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule